// File: doc/BRIEF.md
# Execution Mode and Privilege Controller

This block keeps track of where a small processor core is running and how much it is allowed to do. There are two execution modes: thread mode for ordinary code and handler mode for exception service. There are also two access levels, privileged and unprivileged. The exception logic drives one-cycle entry and return strobes. A two-bit control register, written through its own port, sets the thread-mode access level and the thread-mode stack choice. The block grants or refuses requests to reach the special registers according to the effective access level.

The block also owns the two banked stack pointers, a main one and a process one. Register index 13 of the 16-entry register file is the stack pointer. A read or write at that index reaches whichever bank the current mode and control bits select. The rest of the register file, instruction decode and exception prioritisation are handled elsewhere.

Control register encoding: bit 0 set means thread mode runs unprivileged. Bit 1 set means thread mode uses the process stack. Handler mode always runs privileged on the main stack, whatever these bits hold. Once thread code has dropped its privilege, it cannot restore it with its own write. Only handler code can clear the bit.

Top module: `mode_priv_unit`

## Requirements
- R1: While reset is asserted and after its release, the block is in thread mode (`modeHandler`=0), privileged (`privOn`=1), on the main stack (`spSelProc`=0), with the control register at 0, both stack banks at their reset values, and `ctlFault`, `sregGrant` and `sregFault` all at 0.
- R2: An `excEnter` pulse puts the block in handler mode at the next clock edge. It does so from either mode.
- R3: An `excReturn` pulse without `excEnter` puts the block in thread mode at the next clock edge. Privilege then equals NOT control bit 0, and the stack choice equals control bit 1.
- R4: In handler mode `privOn` is 1 and `spSelProc` is 0, whatever the control register holds.
- R5: A control write (`ctlWrValid`=1) made while privileged, in either mode, loads `ctlWrData` into the control register at the next edge. `ctlView` shows the stored value.
- R6: A control write made while unprivileged leaves the control register unchanged and raises `ctlFault` for exactly the next cycle. As a result, unprivileged thread code cannot clear bit 0.
- R7: A special-register request (`sregReq`=1) produces, in the next cycle, `sregGrant`=1 if the block was privileged at the request and `sregFault`=1 otherwise. The two are never high together.
- R8: A write with `wrEn`=1 and `wrIdx`=13 updates only the currently selected stack bank. `spRdData` with `rdIdx`=13 returns the currently selected bank.
- R9: When `excEnter` and `excReturn` arrive together, entry wins. A return seen in thread mode leaves the mode unchanged.
- R10: Writes to any index other than 13 change neither stack bank, and reads at any other index return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excEnter | input | 1 | Exception entry strobe |
| excReturn | input | 1 | Exception return strobe |
| ctlWrValid | input | 1 | Control register write valid |
| ctlWrData | input | 2 | Control write data (bit 0 unprivileged thread, bit 1 process stack) |
| sregReq | input | 1 | Special-register access request |
| wrEn | input | 1 | Register write enable |
| wrIdx | input | IDX_W | Register write index |
| wrData | input | DATA_W | Register write data |
| rdIdx | input | IDX_W | Register read index |
| modeHandler | output | 1 | 1 = handler mode, 0 = thread mode |
| privOn | output | 1 | Effective privilege |
| spSelProc | output | 1 | 1 = process stack selected |
| ctlView | output | 2 | Current control register contents |
| ctlFault | output | 1 | One-cycle pulse for a refused control write |
| sregGrant | output | 1 | Special-register access granted |
| sregFault | output | 1 | Special-register access refused |
| spRdData | output | DATA_W | Read data of the selected stack bank at index 13, otherwise 0 |

## Verification
The bench runs a directed sequence through every mode and control-bit combination. It enters handler mode from privileged thread code, changes the control bits inside the handler, and returns into unprivileged thread code. This shows that the access level comes from the bits in thread mode and is forced on in handler mode. In the unprivileged state it attempts control writes and special-register requests, which separates dropped writes from accepted ones and grants from faults. Stack writes are made under each selection and read back under the other, which exposes a write that reaches the wrong bank. Collided strobes, returns made in thread mode and off-index writes are mixed in, followed by a long stretch of pseudo-random stimulus. A cycle-level reference model checks every output on every clock.

// File: rtl/mode_priv_pkg.sv
package mode_priv_pkg;
  localparam int CTL_W = 2;
  localparam int CTL_UNPRIV_BIT = 0;
  localparam int CTL_PROC_BIT = 1;

  typedef enum logic {
    MODE_THREAD  = 1'b0,
    MODE_HANDLER = 1'b1
  } mode_e;

  typedef struct packed {
    logic             ctlLoad;
    logic [CTL_W-1:0] ctlData;
    logic             spWrMain;
    logic             spWrProc;
  } dpStrobe_t;
endpackage

// File: rtl/mode_priv_ctrl.sv
module mode_priv_ctrl
  import mode_priv_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int SP_IDX = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             excEnter,
  input  logic             excReturn,
  input  logic             ctlWrValid,
  input  logic [CTL_W-1:0] ctlWrData,
  input  logic             sregReq,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [CTL_W-1:0] ctlBits,
  output logic             modeHandler,
  output logic             privOn,
  output logic             spSelProc,
  output logic             ctlFault,
  output logic             sregGrant,
  output logic             sregFault,
  output dpStrobe_t        stb
);
  localparam logic [IDX_W-1:0] SP_SEL = IDX_W'(SP_IDX);

  mode_e modeQ, modeD;

  // entry beats return; return while in thread is a no-op
  always_comb begin
    modeD = modeQ;
    if (excEnter)       modeD = MODE_HANDLER;
    else if (excReturn) modeD = MODE_THREAD;
  end

  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= MODE_THREAD;
    else       modeQ <= modeD;
  end

  logic inHandler;
  assign inHandler   = (modeQ == MODE_HANDLER);
  assign modeHandler = inHandler;
  assign privOn      = inHandler || !ctlBits[CTL_UNPRIV_BIT];
  assign spSelProc   = !inHandler && ctlBits[CTL_PROC_BIT];

  logic spHit;
  assign spHit = wrEn && (wrIdx == SP_SEL);

  always_comb begin
    stb          = '0;
    stb.ctlLoad  = ctlWrValid && privOn;
    stb.ctlData  = ctlWrData;
    stb.spWrMain = spHit && !spSelProc;
    stb.spWrProc = spHit && spSelProc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlFault  <= 1'b0;
      sregGrant <= 1'b0;
      sregFault <= 1'b0;
    end else begin
      ctlFault  <= ctlWrValid && !privOn;
      sregGrant <= sregReq && privOn;
      sregFault <= sregReq && !privOn;
    end
  end

  p_entry_r2: assert property (@(posedge clk) disable iff (!rstN)
    excEnter |=> modeHandler);
  p_return_r3: assert property (@(posedge clk) disable iff (!rstN)
    (excReturn && !excEnter) |=> (!modeHandler && privOn == !ctlBits[CTL_UNPRIV_BIT]));
  p_handler_priv_r4: assert property (@(posedge clk) disable iff (!rstN)
    modeHandler |-> (privOn && !spSelProc));
  p_drop_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrValid && !privOn) |=> (ctlFault && ctlBits == $past(ctlBits)));
  p_one_answer_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sregGrant, sregFault}));
  p_answer_r7: assert property (@(posedge clk) disable iff (!rstN)
    sregReq |=> (sregGrant != sregFault));
  p_thread_return_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!modeHandler && excReturn && !excEnter) |=> !modeHandler);
endmodule

// File: rtl/mode_priv_dp.sv
module mode_priv_dp
  import mode_priv_pkg::*;
#(
  parameter int              DATA_W  = 32,
  parameter int              IDX_W   = 4,
  parameter int              SP_IDX  = 13,
  parameter logic [DATA_W-1:0] MSP_RST = '0,
  parameter logic [DATA_W-1:0] PSP_RST = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic              spSelProc,
  output logic [CTL_W-1:0]  ctlBits,
  output logic [DATA_W-1:0] spRdData
);
  localparam int NBANK = 2;
  localparam logic [IDX_W-1:0] SP_SEL = IDX_W'(SP_IDX);

  logic [DATA_W-1:0] bankQ [NBANK];
  logic [NBANK-1:0]  bankWe;
  logic [DATA_W-1:0] bankRst [NBANK];

  assign bankWe     = {stb.spWrProc, stb.spWrMain};
  assign bankRst[0] = MSP_RST;
  assign bankRst[1] = PSP_RST;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN)          bankQ[b] <= bankRst[b];
      else if (bankWe[b]) bankQ[b] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           ctlBits <= '0;
    else if (stb.ctlLoad) ctlBits <= stb.ctlData;
  end

  assign spRdData = (rdIdx == SP_SEL) ? bankQ[spSelProc] : '0;

  p_main_only_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.spWrMain |=> (bankQ[1] == $past(bankQ[1]) && bankQ[0] == $past(wrData)));
  p_proc_only_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.spWrProc |=> (bankQ[0] == $past(bankQ[0]) && bankQ[1] == $past(wrData)));
  p_ctl_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.ctlLoad |=> (ctlBits == $past(stb.ctlData)));
endmodule

// File: rtl/mode_priv_unit.sv
module mode_priv_unit
  import mode_priv_pkg::*;
#(
  parameter int              DATA_W  = 32,
  parameter int              IDX_W   = 4,
  parameter int              SP_IDX  = 13,
  parameter logic [DATA_W-1:0] MSP_RST = '0,
  parameter logic [DATA_W-1:0] PSP_RST = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              excEnter,
  input  logic              excReturn,
  input  logic              ctlWrValid,
  input  logic [1:0]        ctlWrData,
  input  logic              sregReq,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic              modeHandler,
  output logic              privOn,
  output logic              spSelProc,
  output logic [1:0]        ctlView,
  output logic              ctlFault,
  output logic              sregGrant,
  output logic              sregFault,
  output logic [DATA_W-1:0] spRdData
);
  dpStrobe_t        stb;
  logic [CTL_W-1:0] ctlBits;

  assign ctlView = ctlBits;

  mode_priv_ctrl #(.IDX_W(IDX_W), .SP_IDX(SP_IDX)) u_ctrl (
    .clk(clk), .rstN(rstN), .excEnter(excEnter), .excReturn(excReturn),
    .ctlWrValid(ctlWrValid), .ctlWrData(ctlWrData), .sregReq(sregReq),
    .wrEn(wrEn), .wrIdx(wrIdx), .ctlBits(ctlBits),
    .modeHandler(modeHandler), .privOn(privOn), .spSelProc(spSelProc),
    .ctlFault(ctlFault), .sregGrant(sregGrant), .sregFault(sregFault), .stb(stb)
  );

  mode_priv_dp #(.DATA_W(DATA_W), .IDX_W(IDX_W), .SP_IDX(SP_IDX),
                 .MSP_RST(MSP_RST), .PSP_RST(PSP_RST)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .rdIdx(rdIdx),
    .spSelProc(spSelProc), .ctlBits(ctlBits), .spRdData(spRdData)
  );

  p_reset_r1: assert property (@(posedge clk)
    !rstN |=> (!modeHandler && privOn && !spSelProc && ctlView == 2'b00));
endmodule

// File: tb/mode_priv_unit_tb.sv
`timescale 1ns/1ps
module mode_priv_unit_tb;
  localparam int DW = 32;
  localparam int IW = 4;
  localparam logic [DW-1:0] MRST = 32'h2000_1000;
  localparam logic [DW-1:0] PRST = 32'h2000_0800;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic excEnter = 0, excReturn = 0, ctlWrValid = 0, sregReq = 0, wrEn = 0;
  logic [1:0] ctlWrData = 0;
  logic [IW-1:0] wrIdx = 0, rdIdx = 0;
  logic [DW-1:0] wrData = 0;
  logic modeHandler, privOn, spSelProc, ctlFault, sregGrant, sregFault;
  logic [1:0] ctlView;
  logic [DW-1:0] spRdData;

  always #2 clk = ~clk;

  mode_priv_unit #(.DATA_W(DW), .IDX_W(IW), .SP_IDX(13), .MSP_RST(MRST), .PSP_RST(PRST)) u_dut (
    .clk(clk), .rstN(rstN), .excEnter(excEnter), .excReturn(excReturn),
    .ctlWrValid(ctlWrValid), .ctlWrData(ctlWrData), .sregReq(sregReq),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData), .rdIdx(rdIdx),
    .modeHandler(modeHandler), .privOn(privOn), .spSelProc(spSelProc),
    .ctlView(ctlView), .ctlFault(ctlFault), .sregGrant(sregGrant),
    .sregFault(sregFault), .spRdData(spRdData)
  );

  int nCmp = 0, nBad = 0;
  bit finished = 0;

  // reference state
  bit mH = 0, mF = 0, mG = 0, mS = 0;
  bit [1:0] mC = 0;
  bit [DW-1:0] mM = MRST, mP = PRST;

  task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    bit pr, sp;
    pr = mH || !mC[0];
    sp = !mH && mC[1];
    chk(tag, "modeHandler", DW'(modeHandler), DW'(mH));
    chk(tag, "privOn", DW'(privOn), DW'(pr));
    chk(tag, "spSelProc", DW'(spSelProc), DW'(sp));
    chk(tag, "ctlView", DW'(ctlView), DW'(mC));
    chk(tag, "ctlFault", DW'(ctlFault), DW'(mF));
    chk(tag, "sregGrant", DW'(sregGrant), DW'(mG));
    chk(tag, "sregFault", DW'(sregFault), DW'(mS));
    chk(tag, "spRdData", spRdData, (rdIdx == 13) ? (sp ? mP : mM) : '0);
  endtask

  task automatic step(string tag);
    bit pr, sp, nH, nF, nG, nS;
    bit [1:0] nC;
    bit [DW-1:0] nM, nP;
    pr = mH || !mC[0];
    sp = !mH && mC[1];
    nH = excEnter ? 1'b1 : (excReturn ? 1'b0 : mH);
    nC = (ctlWrValid && pr) ? ctlWrData : mC;
    nF = ctlWrValid && !pr;
    nG = sregReq && pr;
    nS = sregReq && !pr;
    nM = mM; nP = mP;
    if (wrEn && wrIdx == 13) begin
      if (sp) nP = wrData; else nM = wrData;
    end
    @(posedge clk);
    mH = nH; mC = nC; mF = nF; mG = nG; mS = nS; mM = nM; mP = nP;
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic clr();
    excEnter = 0; excReturn = 0; ctlWrValid = 0; sregReq = 0; wrEn = 0;
  endtask

  task automatic spWr(logic [DW-1:0] v, logic [IW-1:0] idx);
    clr(); wrEn = 1; wrIdx = idx; wrData = v; rdIdx = 13;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compareAll("R1");
    rstN = 1;
    rdIdx = 13;
    step("R1");
    // R5/R8: privileged thread selects process stack and writes it
    clr(); ctlWrValid = 1; ctlWrData = 2'b10; step("R5");
    spWr(32'hAAAA_0001, 13); step("R8");
    clr(); step("R8");
    clr(); ctlWrValid = 1; ctlWrData = 2'b00; step("R5");
    spWr(32'hBBBB_0002, 13); step("R8");
    clr(); ctlWrValid = 1; ctlWrData = 2'b10; step("R8");
    // R2/R4: entry, handler forced privileged on main stack
    clr(); excEnter = 1; step("R2");
    clr(); ctlWrValid = 1; ctlWrData = 2'b11; step("R4");
    spWr(32'hCCCC_0003, 13); step("R8");
    clr(); sregReq = 1; step("R7");
    // R3: return into unprivileged thread on process stack
    clr(); excReturn = 1; step("R3");
    clr(); step("R3");
    // R6/R7: unprivileged attempts
    clr(); sregReq = 1; step("R7");
    clr(); ctlWrValid = 1; ctlWrData = 2'b00; step("R6");
    clr(); step("R6");
    // R10: off-index write ignored, off-index read zero
    spWr(32'hDEAD_BEEF, 14); step("R10");
    clr(); rdIdx = 14; step("R10");
    clr(); rdIdx = 13; step("R10");
    // R9: collision and thread-mode return
    clr(); excEnter = 1; excReturn = 1; step("R9");
    clr(); excEnter = 1; step("R9");
    clr(); ctlWrValid = 1; ctlWrData = 2'b00; step("R6");
    clr(); excReturn = 1; step("R3");
    clr(); excReturn = 1; step("R9");
    // mixed pseudo-random stretch
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      excEnter = (r[3:0] == 0); excReturn = (r[7:4] < 2);
      ctlWrValid = r[8] & r[9]; ctlWrData = r[11:10];
      sregReq = r[12]; wrEn = r[13];
      wrIdx = r[14] ? 4'd13 : r[19:16];
      rdIdx = r[15] ? 4'd13 : r[23:20];
      wrData = $urandom;
      step("R8");
    end
    clr();
    step("R1");
    finished = 1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nCmp++; nBad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end
endmodule